// File: doc/BRIEF.md
# Receive Frame Buffer Writer

This block sits between the receive side of an Ethernet MAC and the packet memory. It accepts a received frame as a stream of bytes, bracketed by a start pulse and an end pulse, and lays the frame into a 16-bit-wide buffer. Each stored frame has a fixed structure. Word 0 is the frame status word. Word 1 is the structure length in bytes. The data area starts at word 2, and a control word that records whether the data length is odd or even closes the structure. Every byte is stored exactly as it arrived, including the address fields and the length/type field.

Address filtering, CRC checking, alignment detection and buffer allocation are done elsewhere. Their results are presented as flag inputs when the frame ends, together with a multicast hash value, and are folded into the status word. The buffer's starting word address is supplied on `buf_base` and captured at frame start.

The status word and the length are only known when the frame ends. The writer therefore streams the data words first, then writes the control word, then the status word and the length word. It pulses `done` after that, so a reader never sees a partially built header.

Top module: `rxbuf_writer`

## Requirements
- R1: After reset, and until a frame is started with `rx_start`, `mem_we` and `done` stay low and nothing is written.
- R2: Data byte k of a frame, counted from 0, is stored unchanged in word `base+2+k/2`: even k in bits 7:0 and odd k in bits 15:8.
- R3: When the stored data count n is even, the control word `0x0000` is written at word `base+2+n/2`. Its low byte is padding and its ODD bit (bit 13 of the word, bit 5 of the control byte) is clear.
- R4: When n is odd, the control word at `base+2+(n-1)/2` carries the last data byte in bits 7:0 and `0x20` in bits 15:8, which means the ODD bit is set.
- R5: Word `base+1` holds the structure length in bytes, counted from the status word through the control word: n+5 for odd n and n+6 for even n.
- R6: Word `base` holds the status word. Its fields are: hash in bits 15:10, bits 9:7 zero, alignment error in bit 6, broadcast in bit 5, bad CRC in bit 4, odd in bit 3, too long in bit 2, too short in bit 1 and multicast in bit 0. The flag and hash inputs are sampled in the cycle in which `rx_end` is high.
- R7: The odd bit equals n mod 2. The too-short bit is set when n is below MIN_LEN (64 by default).
- R8: When more than MAX_DATA (2043) bytes arrive, only the first MAX_DATA bytes are stored, the too-long bit is set, n counts as MAX_DATA, and nothing is written past the control word.
- R9: The write order is: data words, then the control word, then the status word, then the length word. `done` goes high for exactly one cycle, in the cycle after the length word write.
- R10: Bytes offered while no frame is open, cycles inside a frame with `rx_valid` low, and the data lane in the `rx_end` cycle all cause no write. The number of writes per frame is floor(n/2)+3.
- R11: `buf_base` is captured with `rx_start`. Changing it later in the frame does not move where that frame is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Opens a frame when the writer is idle |
| rx_valid | input | 1 | `rx_data` holds a frame byte this cycle |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | Closes the open frame; flags are sampled with it |
| rx_align_err | input | 1 | Alignment error result |
| rx_bcast | input | 1 | Broadcast destination result |
| rx_mcast | input | 1 | Multicast destination result |
| rx_crc_bad | input | 1 | CRC check failed |
| rx_hash | input | 6 | Multicast hash value |
| buf_base | input | ADDR_W | Word address of the allocated buffer |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | ADDR_W | Buffer word address |
| mem_wdata | output | 16 | Buffer write data |
| done | output | 1 | One-cycle pulse when the frame is committed |

## Verification
The hardest condition to reach from the ports is the length cap. It takes a frame longer than the data area can hold, so the bench streams 2050 bytes into one frame. It then checks that storage stopped at byte 2042, that the control word sits in the last word of the region, and that the word after it still holds its fill pattern. Odd and even endings near the short-frame limit (63, 64 and 65 bytes), an empty frame, frames with idle gaps between bytes, and a buffer base changed during a frame are walked from a vector table. Each case is compared against a memory image that is filled with a sentinel before the frame.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    localparam int BYTE_W       = 8;
    localparam int WORD_W       = 16;
    localparam int HASH_W       = 6;
    localparam int CTRL_ODD_BIT = 5;

    // Status word as laid out in buffer word 0
    typedef struct packed {
        logic [HASH_W-1:0] hash;
        logic [2:0]        rsvd;
        logic              align_err;
        logic              bcast;
        logic              bad_crc;
        logic              odd;
        logic              too_long;
        logic              too_short;
        logic              mcast;
    } rx_status_t;

    // Results delivered by neighbouring logic at frame end
    typedef struct packed {
        logic              align_err;
        logic              bcast;
        logic              bad_crc;
        logic              mcast;
        logic [HASH_W-1:0] hash;
    } rx_flags_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_CTRL,
        ST_STAT,
        ST_CNT,
        ST_DONE
    } wr_state_t;

    function automatic logic [WORD_W-1:0] ctrl_word(input logic odd,
                                                   input logic [BYTE_W-1:0] last);
        logic [BYTE_W-1:0] c;
        c = '0;
        c[CTRL_ODD_BIT] = odd;
        return {c, (odd ? last : {BYTE_W{1'b0}})};
    endfunction

    // Bytes from status word through control word inclusive
    function automatic logic [WORD_W-1:0] struct_len(input logic [WORD_W-1:0] n);
        return n[0] ? (n + 16'd5) : (n + 16'd6);
    endfunction

endpackage

// File: rtl/rxw_packer.sv
module rxw_packer
    import rxw_pkg::*;
#(
    parameter int MAX_DATA = 2043,
    parameter int CNT_W    = $clog2(MAX_DATA + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               byte_vld,
    input  logic [BYTE_W-1:0]  byte_in,
    output logic               pair_fire,
    output logic [WORD_W-1:0]  pair_word,
    output logic [CNT_W-1:0]   pair_idx,
    output logic [CNT_W-1:0]   byte_cnt,
    output logic [BYTE_W-1:0]  held_lo,
    output logic               overflow
);

    logic full;
    logic take;

    assign full      = (byte_cnt == CNT_W'(MAX_DATA));
    assign take      = byte_vld && !full;
    assign pair_fire = take && byte_cnt[0];
    assign pair_word = {byte_in, held_lo};
    assign pair_idx  = byte_cnt >> 1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            byte_cnt <= '0;
            held_lo  <= '0;
            overflow <= 1'b0;
        end else begin
            if (take) begin
                byte_cnt <= byte_cnt + 1'b1;
                if (!byte_cnt[0]) begin
                    held_lo <= byte_in;
                end
            end
            if (byte_vld && full) begin
                overflow <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxw_status.sv
module rxw_status
    import rxw_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  rx_flags_t        flags,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             overflow,
    output rx_status_t       status_q
);

    rx_status_t status_d;

    always_comb begin
        status_d           = '0;
        status_d.hash      = flags.hash;
        status_d.align_err = flags.align_err;
        status_d.bcast     = flags.bcast;
        status_d.bad_crc   = flags.bad_crc;
        status_d.mcast     = flags.mcast;
        status_d.odd       = byte_cnt[0];
        status_d.too_long  = overflow;
        status_d.too_short = (int'(byte_cnt) < MIN_LEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else if (capture) begin
            status_q <= status_d;
        end
    end

endmodule

// File: rtl/rxw_wport.sv
module rxw_wport
    import rxw_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_start,
    input  logic              rx_end,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              pair_fire,
    input  logic [WORD_W-1:0] pair_word,
    input  logic [CNT_W-1:0]  pair_idx,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic [BYTE_W-1:0] held_lo,
    input  rx_status_t        status_q,
    output logic              frame_clear,
    output logic              recv_on,
    output logic              capture,
    output logic              idle,
    output logic [ADDR_W-1:0] base_q,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              done
);

    localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] CNT_OFS  = ADDR_W'(1);

    wr_state_t state;

    assign idle        = (state == ST_IDLE);
    assign recv_on     = (state == ST_RECV);
    assign frame_clear = idle && rx_start;
    assign capture     = recv_on && rx_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            base_q    <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            done   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (rx_start) begin
                        base_q <= base_in;
                        state  <= ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (rx_end) begin
                        state <= ST_CTRL;
                    end else if (pair_fire) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= base_q + DATA_OFS + ADDR_W'(pair_idx);
                        mem_wdata <= pair_word;
                    end
                end
                ST_CTRL: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= base_q + DATA_OFS + ADDR_W'(byte_cnt >> 1);
                    mem_wdata <= ctrl_word(byte_cnt[0], held_lo);
                    state     <= ST_STAT;
                end
                ST_STAT: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= base_q;
                    mem_wdata <= status_q;
                    state     <= ST_CNT;
                end
                ST_CNT: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= base_q + CNT_OFS;
                    mem_wdata <= struct_len(WORD_W'(byte_cnt));
                    state     <= ST_DONE;
                end
                ST_DONE: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rxbuf_writer.sv
module rxbuf_writer
    import rxw_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int MAX_DATA = 2043,
    parameter int MIN_LEN  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_start,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_end,
    input  logic              rx_align_err,
    input  logic              rx_bcast,
    input  logic              rx_mcast,
    input  logic              rx_crc_bad,
    input  logic [HASH_W-1:0] rx_hash,
    input  logic [ADDR_W-1:0] buf_base,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              done
);

    localparam int CNT_W = $clog2(MAX_DATA + 1);

    logic              frame_clear;
    logic              recv_on;
    logic              capture;
    logic              wr_idle;
    logic              byte_vld;
    logic              pair_fire;
    logic [WORD_W-1:0] pair_word;
    logic [CNT_W-1:0]  pair_idx;
    logic [CNT_W-1:0]  byte_cnt;
    logic [BYTE_W-1:0] held_lo;
    logic              overflow;
    logic [ADDR_W-1:0] frame_base;
    rx_flags_t         flags;
    rx_status_t        status_q;

    // the lane is not sampled in the closing cycle
    assign byte_vld = recv_on && rx_valid && !rx_end;

    always_comb begin
        flags           = '0;
        flags.align_err = rx_align_err;
        flags.bcast     = rx_bcast;
        flags.bad_crc   = rx_crc_bad;
        flags.mcast     = rx_mcast;
        flags.hash      = rx_hash;
    end

    rxw_packer #(
        .MAX_DATA (MAX_DATA),
        .CNT_W    (CNT_W)
    ) u_packer (
        .clk       (clk),
        .rst       (rst),
        .clear     (frame_clear),
        .byte_vld  (byte_vld),
        .byte_in   (rx_data),
        .pair_fire (pair_fire),
        .pair_word (pair_word),
        .pair_idx  (pair_idx),
        .byte_cnt  (byte_cnt),
        .held_lo   (held_lo),
        .overflow  (overflow)
    );

    rxw_status #(
        .CNT_W   (CNT_W),
        .MIN_LEN (MIN_LEN)
    ) u_status (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .flags    (flags),
        .byte_cnt (byte_cnt),
        .overflow (overflow),
        .status_q (status_q)
    );

    rxw_wport #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_wport (
        .clk         (clk),
        .rst         (rst),
        .rx_start    (rx_start),
        .rx_end      (rx_end),
        .base_in     (buf_base),
        .pair_fire   (pair_fire),
        .pair_word   (pair_word),
        .pair_idx    (pair_idx),
        .byte_cnt    (byte_cnt),
        .held_lo     (held_lo),
        .status_q    (status_q),
        .frame_clear (frame_clear),
        .recv_on     (recv_on),
        .capture     (capture),
        .idle        (wr_idle),
        .base_q      (frame_base),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .done        (done)
    );

endmodule

// File: rtl/rxbuf_writer_chk.sv
module rxbuf_writer_chk #(
    parameter int ADDR_W   = 11,
    parameter int MAX_DATA = 2043,
    parameter int CNT_W    = $clog2(MAX_DATA + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic [ADDR_W-1:0] frame_base,
    input logic [CNT_W-1:0]  byte_cnt,
    input logic              wr_idle
);

    localparam int FRAME_WORDS = 2 + (MAX_DATA + 2) / 2;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        wr_idle |-> !mem_we);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    cnt_before_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(mem_we) && ($past(mem_addr) == frame_base + ADDR_W'(1))));

    // R9
    stat_before_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(mem_we, 2) && ($past(mem_addr, 2) == frame_base)));

    // R8
    region_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (int'(ADDR_W'(mem_addr - frame_base)) < FRAME_WORDS));

    // R8
    cap_chk: assert property (@(posedge clk) disable iff (rst)
        int'(byte_cnt) <= MAX_DATA);

endmodule

bind rxbuf_writer rxbuf_writer_chk #(
    .ADDR_W   (ADDR_W),
    .MAX_DATA (MAX_DATA)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .done       (done),
    .frame_base (frame_base),
    .byte_cnt   (byte_cnt),
    .wr_idle    (wr_idle)
);

// File: tb/rxbuf_writer_tb.sv
`timescale 1ns/1ps
module rxbuf_writer_tb;

    localparam int ADDR_W = 11;
    localparam int MEM_N  = 2048;
    localparam int MAXD   = 2043;

    typedef struct packed {
        logic [11:0] n;
        logic [10:0] base;
        logic [3:0]  fl;    // align, bcast, bad crc, mcast
        logic [5:0]  h;
        logic        gap;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{12'd0,  11'd10,   4'b0000, 6'd0,  1'b0},
        '{12'd1,  11'd20,   4'b0100, 6'd5,  1'b0},
        '{12'd2,  11'd40,   4'b0001, 6'd63, 1'b0},
        '{12'd17, 11'd60,   4'b1000, 6'd0,  1'b1},
        '{12'd63, 11'd100,  4'b0010, 6'd12, 1'b0},
        '{12'd64, 11'd200,  4'b0101, 6'd33, 1'b0},
        '{12'd65, 11'd300,  4'b1111, 6'd1,  1'b1},
        '{12'd30, 11'd2000, 4'b0000, 6'd7,  1'b0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rx_start = 1'b0;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = 8'h00;
    logic              rx_end = 1'b0;
    logic              rx_align_err = 1'b0;
    logic              rx_bcast = 1'b0;
    logic              rx_mcast = 1'b0;
    logic              rx_crc_bad = 1'b0;
    logic [5:0]        rx_hash = 6'd0;
    logic [ADDR_W-1:0] buf_base = '0;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0]       mem_wdata;
    logic              done;

    logic [15:0]       mem [MEM_N];
    int                total = 0;
    int                bad = 0;
    int                wr_count = 0;
    int                done_count = 0;
    logic              done_prev_ok = 1'b0;
    logic              prev_we = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [ADDR_W-1:0] exp_base = '0;
    logic [ADDR_W-1:0] ord0 = '0, ord1 = '0, ord2 = '0;
    logic              finished = 1'b0;

    always #2.5 clk = ~clk;

    rxbuf_writer u_dut (
        .clk          (clk),
        .rst          (rst),
        .rx_start     (rx_start),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_end       (rx_end),
        .rx_align_err (rx_align_err),
        .rx_bcast     (rx_bcast),
        .rx_mcast     (rx_mcast),
        .rx_crc_bad   (rx_crc_bad),
        .rx_hash      (rx_hash),
        .buf_base     (buf_base),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .done         (done)
    );

    always @(negedge clk) begin
        if (done) begin
            done_count   = done_count + 1;
            done_prev_ok = prev_we && (prev_addr == exp_base + ADDR_W'(1));
        end
        if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_count = wr_count + 1;
            ord0 = ord1;
            ord1 = ord2;
            ord2 = mem_addr;
        end
        prev_we   = mem_we;
        prev_addr = mem_addr;
    end

    function automatic logic [7:0] byte_of(input int seed, input int k);
        return 8'(seed * 13 + k * 7 + (k >> 3));
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < MEM_N; i++) mem[i] = 16'hDEAD;
        wr_count   = 0;
        done_count = 0;
    endtask

    task automatic send_frame(input int n, input int base, input int seed, input logic [3:0] fl,
                              input logic [5:0] h, input logic gap, input int base_alt);
        fill_mem();
        exp_base = ADDR_W'(base);
        @(posedge clk); #1;
        rx_start = 1'b1;
        buf_base = ADDR_W'(base);
        @(posedge clk); #1;
        rx_start = 1'b0;
        if (base_alt >= 0) buf_base = ADDR_W'(base_alt);
        for (int k = 0; k < n; k++) begin
            if (gap && (k % 3 == 1)) begin
                rx_valid = 1'b0;
                rx_data  = 8'hFF;
                @(posedge clk); #1;
            end
            rx_valid = 1'b1;
            rx_data  = byte_of(seed, k);
            @(posedge clk); #1;
        end
        rx_valid     = 1'b0;
        rx_end       = 1'b1;
        rx_data      = 8'hA5;
        rx_align_err = fl[3];
        rx_bcast     = fl[2];
        rx_crc_bad   = fl[1];
        rx_mcast     = fl[0];
        rx_hash      = h;
        @(posedge clk); #1;
        rx_end = 1'b0;
        {rx_align_err, rx_bcast, rx_crc_bad, rx_mcast} = 4'b0000;
        rx_hash = 6'd0;
        for (int w = 0; w < 40 && done_count == 0; w++) @(posedge clk);
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_frame(input int n, input int base, input int seed,
                               input logic [3:0] fl, input logic [5:0] h);
        int s;
        int mism;
        int ci;
        logic [15:0] exp_ctrl;
        logic [15:0] exp_stat;
        logic [15:0] w;
        s = (n > MAXD) ? MAXD : n;
        mism = 0;
        for (int k = 0; k < s - (s % 2); k++) begin
            w = mem[ADDR_W'(base + 2 + k / 2)];
            if (((k % 2 == 0) ? w[7:0] : w[15:8]) != byte_of(seed, k)) mism = mism + 1;
        end
        check(mism == 0, "R2 data bytes mismatched", mism, 0);
        ci = base + 2 + s / 2;
        exp_ctrl = (s % 2 == 1) ? {8'h20, byte_of(seed, s - 1)} : 16'h0000;
        check(mem[ADDR_W'(ci)] == exp_ctrl, (s % 2 == 1) ? "R4 odd control word" : "R3 even control word",
              int'(mem[ADDR_W'(ci)]), int'(exp_ctrl));
        check(mem[ADDR_W'(base + 1)] == 16'((s % 2 == 1) ? s + 5 : s + 6), "R5 length word",
              int'(mem[ADDR_W'(base + 1)]), (s % 2 == 1) ? s + 5 : s + 6);
        exp_stat = {h, 3'b000, fl[3], fl[2], fl[1], 1'(s % 2), (n > MAXD), (s < 64), fl[0]};
        w = mem[ADDR_W'(base)];
        check(w == exp_stat, "R6 status word", int'(w), int'(exp_stat));
        check({w[3], w[1]} == {1'(s % 2), (s < 64)}, "R7 odd/short bits", int'({w[3], w[1]}),
              int'({1'(s % 2), (s < 64)}));
        check(w[2] == (n > MAXD), "R8 too-long bit", int'(w[2]), int'(n > MAXD));
        check(mem[ADDR_W'(ci + 1)] == 16'hDEAD, "R8 word past control untouched",
              int'(mem[ADDR_W'(ci + 1)]), 16'hDEAD);
        check(wr_count == s / 2 + 3, "R10 write count", wr_count, s / 2 + 3);
        check(done_count == 1 && done_prev_ok, "R9 single done after length write",
              done_count, 1);
        check(ord0 == ADDR_W'(ci) && ord1 == ADDR_W'(base) && ord2 == ADDR_W'(base + 1),
              "R9 ctrl/status/length order", int'(ord1), base);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1;
        bad   = bad + 1;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        fill_mem();
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(mem_we == 1'b0 && done == 1'b0, "R1 outputs low after reset",
              int'({mem_we, done}), 0);

        // R10 and R1: bytes and an end pulse with no frame open
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #1;
            rx_valid = 1'b1;
            rx_data  = 8'(k * 3 + 1);
            rx_end   = (k == 5);
        end
        @(posedge clk); #1;
        rx_valid = 1'b0;
        rx_end   = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(wr_count == 0, "R10 no writes while idle", wr_count, 0);
        check(done_count == 0, "R1 no done while idle", done_count, 0);

        foreach (VECS[i]) begin
            send_frame(int'(VECS[i].n), int'(VECS[i].base), i + 1, VECS[i].fl,
                       VECS[i].h, VECS[i].gap, -1);
            check_frame(int'(VECS[i].n), int'(VECS[i].base), i + 1, VECS[i].fl, VECS[i].h);
        end

        // R8 length cap
        send_frame(2050, 0, 9, 4'b0000, 6'd2, 1'b0, -1);
        check_frame(2050, 0, 9, 4'b0000, 6'd2);

        // R11 base changed after start
        send_frame(10, 500, 11, 4'b0100, 6'd9, 1'b0, 900);
        check_frame(10, 500, 11, 4'b0100, 6'd9);
        check(mem[900] == 16'hDEAD && mem[902] == 16'hDEAD, "R11 late base ignored",
              int'(mem[902]), 16'hDEAD);

        finish_up();
    end

endmodule